// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it through a small register port. A control register holds a conversion mode, a start bit, an input-enable bit and a channel number. A status register reports whether a conversion is running and whether a finished result is waiting. Two result registers hold the converted value, split into a low part and a high part. Each finished conversion also gives a one-cycle interrupt pulse.

A conversion opens with one sample cycle. Ten bit-decision cycles follow, from the most significant bit down. In each decision cycle the block drives a trial code to the external DAC and reads back one comparator bit. In single mode the block converts once and goes idle. In repeat mode a fresh sample cycle follows each stored result straight away, and this goes on until software writes the stop mode. Writes that would disturb a running conversion are dropped. The one exception is the stop write, which aborts at once and leaves the previous result in place.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, end-of-conversion, the interrupt, the DAC code and sample_en are 0, and all four registers read 0.
- R2: Register map: address 0 is control, with mode in bits [1:0], start in bit 2, input enable in bit 3 and channel in bits [7:4]. An idle write to address 0 stores mode, enable and channel. When start=1, enable=1 and mode is 01 or 11, that write begins a conversion and busy reads 1 from the next cycle. The start bit always reads back as 0.
- R3: An idle start request with enable=0, or with mode 00 or 10, does not begin a conversion. Busy stays 0, and the other fields of that write are still stored.
- R4: A conversion is one cycle with sample_en=1 followed by 10 decision cycles, bit 9 first. During each decision the DAC code is the bits kept so far plus the trial bit. The trial bit is kept when cmp_in is 1. The result becomes visible 11 clock edges after the start edge, including for the values 0 and 1023.
- R5: Address 1 is status, with busy in bit 0 and end-of-conversion in bit 1. Address 2 carries result bits [1:0] in its bits [7:6], and its other bits read 0. Address 3 carries result bits [9:2].
- R6: End-of-conversion sets when a result is stored. A read strobe at address 3 clears it, and a read strobe at address 2 does not. If a result lands in the same cycle as an address-3 read, the flag stays set.
- R7: irq is high for exactly one cycle per stored result, in the first cycle that the new result is visible.
- R8: In single mode (01), busy returns to 0 in the same cycle that the result becomes visible.
- R9: In repeat mode (11), busy stays 1, a sample cycle follows each stored result at once, and results land every 11 cycles.
- R10: A control write with mode 00 while busy stops the conversion. From the next cycle busy is 0 and mode reads 00. No result is stored and no irq occurs, even if the write falls on the completing edge. Earlier result bytes and the end-of-conversion flag are unchanged.
- R11: Any other control write while busy is ignored. Channel, enable and mode read back unchanged, and the conversion goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (side effects only) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data for rd_addr |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC code |
| dac_code | output | 10 | Trial code to the DAC, 0 outside decision cycles |
| sample_en | output | 1 | High during the sample cycle |
| chan_out | output | 4 | Selected analog channel |
| ain_en_out | output | 1 | Analog input enable |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion flag |
| irq | output | 1 | Conversion-finished pulse |

## Verification
Busy and sample_en are due one edge after the start write. The stored result, the end-of-conversion flag and irq are due 11 edges after the start write, and in repeat mode again every 11 edges after that. A stop write or a read strobe acts on the very next edge. The bench drives inputs at the falling edge. Its reference model counts edges from each start on its own, and it compares every output and the read data five nanoseconds after each rising edge, so each check lands in the cycle its result is due. The directed steps place the address-3 read and the stop write on the exact completing edge to cover those collisions.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_LOOP = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SAMPLE = 2'd1,
    SQ_DECIDE = 2'd2
  } sq_state_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd1;
  localparam logic [REG_AW-1:0] RA_RLO  = 2'd2;
  localparam logic [REG_AW-1:0] RA_RHI  = 2'd3;

  localparam int CTL_START_BIT = 2;
  localparam int CTL_EN_BIT    = 3;
  localparam int CTL_CHAN_LSB  = 4;

  function automatic logic mode_runs(input logic [1:0] m);
    return (m == MODE_ONCE) || (m == MODE_LOOP);
  endfunction
endpackage

// File: rtl/adc_ctrl_regs.sv
`timescale 1ns/1ps
module adc_ctrl_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [1:0]        mode,
  output logic              ain_en,
  output logic [CH_W-1:0]   chan,
  output logic              start_evt,
  output logic              abort_evt
);
  logic            ctrl_wr;
  logic [1:0]      wr_mode;
  logic            wr_start;
  logic            wr_en_bit;
  logic [CH_W-1:0] wr_chan;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == RA_CTRL);
    wr_mode   = wr_data[1:0];
    wr_start  = wr_data[CTL_START_BIT];
    wr_en_bit = wr_data[CTL_EN_BIT];
    wr_chan   = wr_data[CTL_CHAN_LSB +: CH_W];
    abort_evt = ctrl_wr && busy && (wr_mode == MODE_STOP);
    start_evt = ctrl_wr && !busy && wr_start && wr_en_bit && mode_runs(wr_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_STOP;
      ain_en <= 1'b0;
      chan   <= '0;
    end else if (ctrl_wr && !busy) begin
      mode   <= wr_mode;
      ain_en <= wr_en_bit;
      chan   <= wr_chan;
    end else if (abort_evt) begin
      mode   <= MODE_STOP;
    end
  end
endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             loop_mode,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sampling,
  output logic             busy,
  output logic             conv_done,
  output logic [RES_W-1:0] conv_value
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] next_acc;
  logic             deciding;

  function automatic logic [RES_W-1:0] trial_code(input logic [RES_W-1:0] kept,
                                                  input logic [IDX_W-1:0] bit_i);
    return kept | (RES_W'(1) << bit_i);
  endfunction

  always_comb begin
    deciding   = (state_q == SQ_DECIDE);
    trial      = trial_code(acc_q, idx_q);
    next_acc   = (deciding && cmp_in) ? trial : acc_q;
    dac_code   = deciding ? trial : '0;
    sampling   = (state_q == SQ_SAMPLE);
    busy       = (state_q != SQ_IDLE);
    conv_done  = deciding && (idx_q == '0) && !abort;
    conv_value = next_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
    end else if (abort) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_SAMPLE;
          acc_q   <= '0;
        end
        SQ_SAMPLE: begin
          state_q <= SQ_DECIDE;
          idx_q   <= TOP_IDX;
        end
        SQ_DECIDE: begin
          acc_q <= next_acc;
          if (idx_q == '0) begin
            if (loop_mode) begin
              state_q <= SQ_SAMPLE;
              acc_q   <= '0;
            end else begin
              state_q <= SQ_IDLE;
            end
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
`timescale 1ns/1ps
module adc_result_regs #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_value,
  input  logic             hi_read,
  output logic [RES_W-1:0] result,
  output logic             eoc,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      eoc    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= conv_done;
      if (conv_done) begin
        result <= conv_value;
        eoc    <= 1'b1;
      end else if (hi_read) begin
        eoc    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic              sample_en,
  output logic [CH_W-1:0]   chan_out,
  output logic              ain_en_out,
  output logic              busy,
  output logic              eoc,
  output logic              irq
);
  localparam int LO_BITS = RES_W - DATA_W;
  localparam int LO_PAD  = DATA_W - LO_BITS;
  localparam int ST_PAD  = DATA_W - 2;

  logic [1:0]       mode;
  logic             start_evt;
  logic             abort_evt;
  logic             conv_done;
  logic [RES_W-1:0] conv_value;
  logic [RES_W-1:0] result;
  logic             hi_read;

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [CH_W-1:0] c,
                                                  input logic e, input logic [1:0] m);
    return {c, e, 1'b0, m};
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic b, input logic d);
    return {{ST_PAD{1'b0}}, d, b};
  endfunction

  function automatic logic [DATA_W-1:0] res_lo_byte(input logic [RES_W-1:0] r);
    return {r[LO_BITS-1:0], {LO_PAD{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] res_hi_byte(input logic [RES_W-1:0] r);
    return r[RES_W-1 -: DATA_W];
  endfunction

  assign hi_read = rd_en && (rd_addr == RA_RHI);

  adc_ctrl_regs #(.DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .mode(mode), .ain_en(ain_en_out), .chan(chan_out),
    .start_evt(start_evt), .abort_evt(abort_evt)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .abort(abort_evt),
    .loop_mode(mode == MODE_LOOP), .cmp_in(cmp_in), .dac_code(dac_code),
    .sampling(sample_en), .busy(busy), .conv_done(conv_done), .conv_value(conv_value)
  );

  adc_result_regs #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
    .hi_read(hi_read), .result(result), .eoc(eoc), .irq(irq)
  );

  always_comb begin
    case (rd_addr)
      RA_CTRL: rd_data = pack_ctrl(chan_out, ain_en_out, mode);
      RA_STAT: rd_data = pack_stat(busy, eoc);
      RA_RLO:  rd_data = res_lo_byte(result);
      default: rd_data = res_hi_byte(result);
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             abort_evt,
  input logic             conv_done,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic             busy,
  input logic             eoc,
  input logic             irq,
  input logic             sample_en,
  input logic [RES_W-1:0] dac_code,
  input logic [CH_W-1:0]  chan_out,
  input logic             ain_en_out
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && sample_en));

  assert_idle_dac_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  assert_lo_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd2 && eoc) |=> eoc);

  assert_hi_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3 && !conv_done) |=> !eoc);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_with_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eoc);

  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !irq));

  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort_evt) |=> ($stable(chan_out) && $stable(ain_en_out)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .abort_evt(abort_evt),
  .conv_done(conv_done), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .eoc(eoc),
  .irq(irq), .sample_en(sample_en), .dac_code(dac_code), .chan_out(chan_out),
  .ain_en_out(ain_en_out)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sample_en, ain_en_out, busy, eoc, irq;
  logic [3:0] chan_out;

  int analog [16];
  int n_cmp = 0;
  int n_bad = 0;
  bit run_cmp = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cmp_in = (analog[chan_out] >= int'(dac_code));

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_en(sample_en), .chan_out(chan_out),
    .ain_en_out(ain_en_out), .busy(busy), .eoc(eoc), .irq(irq)
  );

  // Behavioural reference: counts edges since each start.
  int m_busy, m_eoc, m_irq, m_mode, m_en, m_chan, m_cnt, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_eoc = 0; m_irq = 0; m_mode = 0; m_en = 0; m_chan = 0; m_cnt = 0; m_res = 0;
    end else begin
      int was_busy;
      bit stop, done, cwr;
      was_busy = m_busy;
      cwr  = wr_en && (wr_addr == 2'd0);
      stop = cwr && (was_busy != 0) && (wr_data[1:0] == 2'b00);
      done = 0;
      m_irq = 0;
      if (was_busy != 0 && !stop) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 11) done = 1;
      end
      if (done) begin
        m_res = analog[m_chan]; m_eoc = 1; m_irq = 1;
        if (m_mode == 1) m_busy = 0; else m_cnt = 0;
      end else if (rd_en && rd_addr == 2'd3) begin
        m_eoc = 0;
      end
      if (cwr) begin
        if (was_busy != 0) begin
          if (stop) begin m_busy = 0; m_mode = 0; end
        end else begin
          m_mode = wr_data[1:0]; m_en = wr_data[3]; m_chan = wr_data[7:4];
          if (wr_data[2] && wr_data[3] && (wr_data[1:0] == 2'b01 || wr_data[1:0] == 2'b11)) begin
            m_busy = 1; m_cnt = 0;
          end
        end
      end
    end
  end

  function automatic int model_rd(input logic [1:0] a);
    case (a)
      2'd0: return (m_chan << 4) | (m_en << 3) | m_mode;
      2'd1: return (m_eoc << 1) | m_busy;
      2'd2: return (m_res & 3) << 6;
      default: return (m_res >> 2) & 8'hFF;
    endcase
  endfunction

  task automatic cmp(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && run_cmp && !finished) begin
      cmp("R8/R9 busy", busy, m_busy);
      cmp("R6 eoc", eoc, m_eoc);
      cmp("R7 irq", irq, m_irq);
      cmp("R4 sample_en", sample_en, (m_busy != 0 && m_cnt == 0) ? 1 : 0);
      cmp("R11 chan_out", chan_out, m_chan);
      cmp("R5 rd_data", rd_data, model_rd(rd_addr));
    end
  end

  task automatic wr_ctrl(input logic [7:0] d);
    wr_en = 1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic strobe(input logic [1:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_irq;
    for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    for (int i = 0; i < 16; i++) analog[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 busy", busy, 0); cmp("R1 eoc", eoc, 0); cmp("R1 irq", irq, 0);
    cmp("R1 dac", dac_code, 0); cmp("R1 sample_en", sample_en, 0);
    for (int a = 0; a < 4; a++) begin peek(2'(a), v); cmp("R1 reg", v, 0); end

    // R3 start with enable off, then with mode 10
    analog[2] = 100;
    wr_ctrl(8'h25); repeat (2) @(negedge clk);
    cmp("R3 busy en0", busy, 0); peek(2'd0, v); cmp("R3 ctrl stored", v, 8'h21);
    wr_ctrl(8'h2E); repeat (2) @(negedge clk);
    cmp("R3 busy mode10", busy, 0); peek(2'd0, v); cmp("R3 ctrl stored", v, 8'h2A);

    // R2 R4 R8 single conversion
    analog[3] = 10'h2A7;
    wr_ctrl(8'h3D);
    cmp("R2 busy", busy, 1); cmp("R4 sample", sample_en, 1);
    peek(2'd0, v); cmp("R2 start reads 0", v, 8'h39);
    repeat (10) @(negedge clk);
    cmp("R4 not yet done", irq, 0);
    @(negedge clk);
    cmp("R7 irq", irq, 1); cmp("R6 eoc set", eoc, 1); cmp("R8 busy clear", busy, 0);
    peek(2'd2, v); cmp("R5 low byte", v, 8'hC0);
    peek(2'd3, v); cmp("R5 high byte", v, 8'hA9);
    @(negedge clk);
    cmp("R7 pulse ends", irq, 0);

    // R6 low read keeps, high read clears
    strobe(2'd2); cmp("R6 lo read keeps", eoc, 1);
    strobe(2'd3); cmp("R6 hi read clears", eoc, 0);

    // R9 R11 R6 R10 repeat mode
    analog[5] = 10'h155;
    wr_ctrl(8'h5F);            // start at E0
    wr_ctrl(8'h7F);            // E1: ignored
    wr_ctrl(8'h7D);            // E2: ignored
    peek(2'd0, v); cmp("R11 fields held", v, 8'h5B);
    cmp("R11 still busy", busy, 1);
    repeat (8) @(negedge clk); // after E10
    strobe(2'd3);              // read on completing edge E11
    cmp("R6 collide keeps eoc", eoc, 1); cmp("R9 irq 1st", irq, 1); cmp("R9 busy", busy, 1);
    cmp("R9 resample", sample_en, 1);
    repeat (10) @(negedge clk);
    cmp("R9 no early irq", irq, 0);
    @(negedge clk);            // after E22
    cmp("R9 irq 2nd", irq, 1);
    repeat (10) @(negedge clk);
    wr_ctrl(8'h50);            // stop on completing edge E33
    cmp("R10 busy", busy, 0); cmp("R10 no irq", irq, 0); cmp("R10 eoc kept", eoc, 1);
    peek(2'd0, v); cmp("R10 mode 00", v, 8'h58);
    peek(2'd3, v); cmp("R10 hi kept", v, 8'h55);
    peek(2'd2, v); cmp("R10 lo kept", v, 8'h40);

    // R10 mid-conversion stop
    analog[3] = 10'h3FF;
    wr_ctrl(8'h3F); repeat (4) @(negedge clk);
    wr_ctrl(8'h30);
    repeat (15) @(negedge clk);
    cmp("R10 idle", busy, 0); peek(2'd3, v); cmp("R10 result untouched", v, 8'h55);

    // R4 boundary values
    analog[0] = 0;
    wr_ctrl(8'h0D); wait_irq();
    peek(2'd3, v); cmp("R4 zero hi", v, 0); peek(2'd2, v); cmp("R4 zero lo", v, 0);
    analog[15] = 1023;
    repeat (2) @(negedge clk);
    wr_ctrl(8'hFD); wait_irq();
    peek(2'd3, v); cmp("R4 full hi", v, 8'hFF); peek(2'd2, v); cmp("R4 full lo", v, 8'hC0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule